// File: doc/BRIEF.md
# Peripheral Clock Output Selector

This block is the digital back end of a peripheral clock generator. It receives four free-running source clocks: a reference near 14.3 MHz, a 96 MHz system source, and two audio sources near 49.152 MHz and 67.7376 MHz. From these it produces a set of USB clocks, one I/O clock, a double-rate audio clock, a single-rate audio clock and several buffered copies of the reference. Two select pins pick the audio rate, a test setting or a silent-audio setting. An enable pin releases every clock output to high impedance.

Each source runs a small halving chain whose lanes carry the source divided by 2 and by 4. These are true 50% waveforms. Two glitch-free selectors route the lanes. One serves the USB/I/O pair and chooses between the system source and the reference. The other serves the audio pair and chooses between the reference and the two audio sources, or none at all. A source is connected or released only while both of its lanes sit low, and a source may connect only after every other source of that selector is seen released. The single-rate audio clock is therefore always the second halving of whatever source currently feeds the double-rate audio clock. On the board the select and enable pins are pulled high, so an unstrapped device runs USB and I/O with audio quiet.

Top module: `pclk_out_sel`

## Requirements
- R1: With `out_en` low, every clock output (all USB copies, I/O, both audio, all reference copies) is high impedance for any `sel` value.
- R2: With `out_en` high and `sel` = 2'b00 (test), the USB copies and the double-rate audio output toggle at the reference divided by 2. The I/O and single-rate audio outputs toggle at the reference divided by 4.
- R3: With `sel` = 2'b01, the double-rate audio output is `aud_lo_clk` divided by 2, and the single-rate audio output is `aud_lo_clk` divided by 4.
- R4: With `sel` = 2'b10, the double-rate audio output is `aud_hi_clk` divided by 2, and the single-rate audio output is `aud_hi_clk` divided by 4.
- R5: With `sel` = 2'b11, both audio outputs are driven steadily low while USB and I/O keep running from the system source.
- R6: For any `sel` other than 2'b00, every USB copy is `sys_clk` divided by 2 and the I/O clock is `sys_clk` divided by 4. Each I/O rising edge lines up with a USB falling edge.
- R7: Every reference copy follows `ref_clk` undivided in every enabled setting, test included.
- R8: Every divided output has a high time of exactly half its period.
- R9: A change of `sel` never produces a pulse shorter than the shortest steady half-period of the outputs involved. At most one source feeds each selector at any time, and a source is connected or released only while its lanes are low.
- R10: While `rst` is high, every halving chain and every selector enable is cleared, so the USB, I/O and audio outputs stay low. `rst` is sampled synchronously in each source domain and must be held for several cycles of the slowest source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference source clock, about 14.3 MHz |
| sys_clk | input | 1 | System source clock, 96 MHz |
| aud_lo_clk | input | 1 | Audio source for the lower rate, about 49.152 MHz |
| aud_hi_clk | input | 1 | Audio source for the higher rate, about 67.7376 MHz |
| rst | input | 1 | Synchronous active-high reset, seen by every source domain |
| out_en | input | 1 | Output enable; low releases all clock outputs to high impedance |
| sel | input | 2 | Mode select: 00 test, 01 lower audio rate, 10 higher audio rate, 11 audio off |
| usb_clk | output | N_USB | USB clock copies |
| io_clk | output | 1 | I/O clock, half the USB rate |
| aud2x_clk | output | 1 | Double-rate audio clock |
| aud1x_clk | output | 1 | Single-rate audio clock, half the double rate |
| ref_out | output | N_REF | Undivided reference copies |

## Verification
The bench builds the block with its default parameters: two USB copies, three reference copies and two-stage synchronizers. With two stages, a handoff between any pair of sources completes within a few reference periods, well inside the settling window the bench allows after each select change. The same depth lets a staged sequence of rapid select changes drive both selectors through every source-to-source handoff while the shortest observed high pulse is recorded. Source periods are integers in nanoseconds, so each expected period and high time is an exact number. Any miscount of the halving chains or misrouting of a lane therefore appears directly in the measured period or high time.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;

  // Mode codes carried on the two select pins (bit 1 first).
  typedef enum logic [1:0] {
    MODE_TEST    = 2'b00,
    MODE_AUD_LO  = 2'b01,
    MODE_AUD_HI  = 2'b10,
    MODE_AUD_OFF = 2'b11
  } pclk_mode_e;

  // Lanes per halving chain: lane 0 = source/2, lane 1 = source/4.
  localparam int LANES = 2;

  // Source slots of the USB/I/O selector.
  localparam int USB_SRC_SYS = 0;
  localparam int USB_SRC_REF = 1;
  localparam int USB_NSRC    = 2;

  // Source slots of the audio selector.
  localparam int AUD_SRC_REF = 0;
  localparam int AUD_SRC_LO  = 1;
  localparam int AUD_SRC_HI  = 2;
  localparam int AUD_NSRC    = 3;

endpackage

// File: rtl/pclk_div.sv
`timescale 1ns/1ps
// Halving chain: a binary counter whose bit k is the source divided by 2^(k+1),
// each with an exact 50% duty cycle.
module pclk_div #(
  parameter int N_LANE = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [N_LANE-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q + 1'b1;
  end

endmodule

// File: rtl/pclk_sel_dec.sv
`timescale 1ns/1ps
// Decodes the select pins into one-hot source requests for both selectors.
module pclk_sel_dec
  import pclk_pkg::*;
(
  input  logic [1:0]          sel,
  output logic [USB_NSRC-1:0] usb_req,
  output logic [AUD_NSRC-1:0] aud_req
);

  pclk_mode_e mode;

  always_comb begin
    mode    = pclk_mode_e'(sel);
    usb_req = '0;
    aud_req = '0;
    if (mode == MODE_TEST) usb_req[USB_SRC_REF] = 1'b1;
    else                   usb_req[USB_SRC_SYS] = 1'b1;
    unique case (mode)
      MODE_TEST:    aud_req[AUD_SRC_REF] = 1'b1;
      MODE_AUD_LO:  aud_req[AUD_SRC_LO]  = 1'b1;
      MODE_AUD_HI:  aud_req[AUD_SRC_HI]  = 1'b1;
      MODE_AUD_OFF: aud_req = '0;
      default:      aud_req = '0;
    endcase
  end

endmodule

// File: rtl/pclk_gsel.sv
`timescale 1ns/1ps
// Glitch-free selector over N_SRC asynchronous sources, each bringing N_LANE
// divided lanes. A source's enable changes on its falling edge and only while
// all its lanes are low; it may turn on only once every other enable is seen off.
module pclk_gsel #(
  parameter int N_SRC       = 2,
  parameter int N_LANE      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic [N_SRC-1:0]             src_clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             req,
  input  logic [N_SRC-1:0][N_LANE-1:0] lane_in,
  output logic [N_LANE-1:0]            lane_out,
  output logic [N_SRC-1:0]             en
);

  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [SW-1:0]             req_sync;
    logic [SW-1:0][N_SRC-1:0]  en_sync;
    logic [N_SRC-1:0]          others;
    logic                      lanes_low;
    logic                      en_r;

    assign lanes_low = (lane_in[i] == '0);

    always_comb begin
      others    = en_sync[SW-1];
      others[i] = 1'b0;
    end

    always_ff @(negedge src_clk[i]) begin
      if (rst) begin
        req_sync <= '0;
        en_sync  <= '0;
        en_r     <= 1'b0;
      end else begin
        req_sync <= {req_sync[SW-2:0], req[i]};
        en_sync  <= {en_sync[SW-2:0], en};
        if (lanes_low) en_r <= req_sync[SW-1] & ~(|others);
      end
    end

    assign en[i] = en_r;
  end

  always_comb begin
    lane_out = '0;
    for (int i = 0; i < N_SRC; i++) begin
      lane_out = lane_out | (lane_in[i] & {N_LANE{en[i]}});
    end
  end

endmodule

// File: rtl/pclk_out_sel.sv
`timescale 1ns/1ps
module pclk_out_sel
  import pclk_pkg::*;
#(
  parameter int N_USB       = 2,
  parameter int N_REF       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             sys_clk,
  input  logic             aud_lo_clk,
  input  logic             aud_hi_clk,
  input  logic             rst,
  input  logic             out_en,
  input  logic [1:0]       sel,
  output logic [N_USB-1:0] usb_clk,
  output logic             io_clk,
  output logic             aud2x_clk,
  output logic             aud1x_clk,
  output logic [N_REF-1:0] ref_out
);

  logic [LANES-1:0]    sys_q, ref_q, alo_q, ahi_q;
  logic [USB_NSRC-1:0] usb_req, usb_en;
  logic [AUD_NSRC-1:0] aud_req, aud_en;
  logic [LANES-1:0]    usb_lanes, aud_lanes;

  pclk_div #(.N_LANE(LANES)) u_sys_div (.clk(sys_clk),    .rst(rst), .q(sys_q));
  pclk_div #(.N_LANE(LANES)) u_ref_div (.clk(ref_clk),    .rst(rst), .q(ref_q));
  pclk_div #(.N_LANE(LANES)) u_alo_div (.clk(aud_lo_clk), .rst(rst), .q(alo_q));
  pclk_div #(.N_LANE(LANES)) u_ahi_div (.clk(aud_hi_clk), .rst(rst), .q(ahi_q));

  pclk_sel_dec u_dec (.sel(sel), .usb_req(usb_req), .aud_req(aud_req));

  pclk_gsel #(.N_SRC(USB_NSRC), .N_LANE(LANES), .SYNC_STAGES(SYNC_STAGES)) u_usb_gsel (
    .src_clk ({ref_clk, sys_clk}),
    .rst     (rst),
    .req     (usb_req),
    .lane_in ({ref_q, sys_q}),
    .lane_out(usb_lanes),
    .en      (usb_en)
  );

  pclk_gsel #(.N_SRC(AUD_NSRC), .N_LANE(LANES), .SYNC_STAGES(SYNC_STAGES)) u_aud_gsel (
    .src_clk ({aud_hi_clk, aud_lo_clk, ref_clk}),
    .rst     (rst),
    .req     (aud_req),
    .lane_in ({ahi_q, alo_q, ref_q}),
    .lane_out(aud_lanes),
    .en      (aud_en)
  );

  // Pad stage: enable releases every driver.
  for (genvar k = 0; k < N_USB; k++) begin : g_usb
    assign usb_clk[k] = out_en ? usb_lanes[0] : 1'bz;
  end
  for (genvar k = 0; k < N_REF; k++) begin : g_ref
    assign ref_out[k] = out_en ? ref_clk : 1'bz;
  end
  assign io_clk    = out_en ? usb_lanes[1] : 1'bz;
  assign aud2x_clk = out_en ? aud_lanes[0] : 1'bz;
  assign aud1x_clk = out_en ? aud_lanes[1] : 1'bz;

endmodule

// File: rtl/pclk_out_sel_chk.sv
`timescale 1ns/1ps
module pclk_out_sel_chk (
  input logic       ref_clk,
  input logic       sys_clk,
  input logic       aud_lo_clk,
  input logic       aud_hi_clk,
  input logic       rst,
  input logic [1:0] usb_en,
  input logic [2:0] aud_en,
  input logic [1:0] sys_q,
  input logic [1:0] ref_q,
  input logic [1:0] alo_q,
  input logic [1:0] ahi_q
);

  // R6
  sys_half_chk: assert property (@(posedge sys_clk) disable iff (rst)
    1'b1 |=> sys_q[0] != $past(sys_q[0]));

  // R6
  io_align_chk: assert property (@(posedge sys_clk) disable iff (rst)
    $rose(sys_q[1]) |-> !sys_q[0]);

  // R2
  ref_half_chk: assert property (@(posedge ref_clk) disable iff (rst)
    1'b1 |=> ref_q[0] != $past(ref_q[0]));

  // R3
  alo_half_chk: assert property (@(posedge aud_lo_clk) disable iff (rst)
    1'b1 |=> alo_q[0] != $past(alo_q[0]));

  // R4
  ahi_half_chk: assert property (@(posedge aud_hi_clk) disable iff (rst)
    1'b1 |=> ahi_q[0] != $past(ahi_q[0]));

  // R9
  usb_excl_chk: assert property (@(posedge sys_clk) disable iff (rst)
    $onehot0(usb_en));

  // R9
  aud_excl_chk: assert property (@(posedge aud_hi_clk) disable iff (rst)
    $onehot0(aud_en));

  // R9
  usb_sys_swap_chk: assert property (@(negedge sys_clk) disable iff (rst)
    ($rose(usb_en[0]) || $fell(usb_en[0])) |-> ($past(sys_q) == 2'b00));

  // R9
  aud_lo_swap_chk: assert property (@(negedge aud_lo_clk) disable iff (rst)
    ($rose(aud_en[1]) || $fell(aud_en[1])) |-> ($past(alo_q) == 2'b00));

  // R9
  aud_ref_swap_chk: assert property (@(negedge ref_clk) disable iff (rst)
    ($rose(aud_en[0]) || $fell(aud_en[0])) |-> ($past(ref_q) == 2'b00));

  // R10
  rst_clear_chk: assert property (@(posedge sys_clk)
    rst |=> (sys_q == 2'b00));

endmodule

bind pclk_out_sel pclk_out_sel_chk u_chk (
  .ref_clk   (ref_clk),
  .sys_clk   (sys_clk),
  .aud_lo_clk(aud_lo_clk),
  .aud_hi_clk(aud_hi_clk),
  .rst       (rst),
  .usb_en    (usb_en),
  .aud_en    (aud_en),
  .sys_q     (sys_q),
  .ref_q     (ref_q),
  .alo_q     (alo_q),
  .ahi_q     (ahi_q)
);

// File: tb/pclk_out_sel_bench.sv
`timescale 1ns/1ps
module pclk_out_sel_bench;

  localparam int N_USB = 2;
  localparam int N_REF = 3;
  localparam int N_OUT = 5 + N_REF;
  localparam int STEP_LIM = 1200;   // 0.5 ns polling steps per wait
  localparam int WDOG = 150000;

  logic clk = 1'b0, ref_clk = 1'b0, sys_clk = 1'b0, aud_lo_clk = 1'b0, aud_hi_clk = 1'b0;
  logic rst = 1'b1, out_en = 1'b1;
  logic [1:0] sel = 2'b11;
  logic [N_USB-1:0] usb_clk;
  logic io_clk, aud2x_clk, aud1x_clk;
  logic [N_REF-1:0] ref_out;

  always #2  clk        = ~clk;        // 250 MHz bench clock
  always #35 ref_clk    = ~ref_clk;    // period 70
  always #5  sys_clk    = ~sys_clk;    // period 10
  always #10 aud_lo_clk = ~aud_lo_clk; // period 20
  always #7  aud_hi_clk = ~aud_hi_clk; // period 14

  pclk_out_sel #(.N_USB(N_USB), .N_REF(N_REF), .SYNC_STAGES(2)) u_pclk_out_sel (
    .ref_clk(ref_clk), .sys_clk(sys_clk), .aud_lo_clk(aud_lo_clk), .aud_hi_clk(aud_hi_clk),
    .rst(rst), .out_en(out_en), .sel(sel),
    .usb_clk(usb_clk), .io_clk(io_clk), .aud2x_clk(aud2x_clk), .aud1x_clk(aud1x_clk),
    .ref_out(ref_out)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  // Short-pulse monitor for select handoffs.
  bit  mon_on = 1'b0;
  real rise_a = 0.0, rise_u = 0.0, min_a = 1.0e9, min_u = 1.0e9;
  always @(posedge aud2x_clk) rise_a = $realtime;
  always @(negedge aud2x_clk) if (mon_on && ($realtime - rise_a) < min_a) min_a = $realtime - rise_a;
  always @(posedge usb_clk[0]) rise_u = $realtime;
  always @(negedge usb_clk[0]) if (mon_on && ($realtime - rise_u) < min_u) min_u = $realtime - rise_u;

  function automatic logic probe(int k);
    case (k)
      0: return usb_clk[0];
      1: return usb_clk[1];
      2: return io_clk;
      3: return aud2x_clk;
      4: return aud1x_clk;
      default: return ref_out[k-5];
    endcase
  endfunction

  // Expected period in ns; 0 means no clock on that output.
  function automatic int exp_period(int k, logic [1:0] s, logic oe);
    if (!oe) return 0;
    if (k >= 5) return 70;
    case (k)
      0, 1: return (s == 2'b00) ? 140 : 20;
      2:    return (s == 2'b00) ? 280 : 40;
      3:    case (s) 2'b00: return 140; 2'b01: return 40; 2'b10: return 28; default: return 0; endcase
      default: case (s) 2'b00: return 280; 2'b01: return 80; 2'b10: return 56; default: return 0; endcase
    endcase
  endfunction

  function automatic string req_of(int k, logic [1:0] s, logic oe);
    if (!oe) return "R1";
    if (k >= 5) return "R7";
    if (k <= 2) return (s == 2'b00) ? "R2" : "R6";
    case (s) 2'b00: return "R2"; 2'b01: return "R3"; 2'b10: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int k, output int per, output int hi);
    real t0, t1, t2;
    int n;
    per = 0; hi = 0;
    n = 0; while (probe(k) === 1'b1 && n < STEP_LIM) begin #0.5; n++; end
    n = 0; while (probe(k) !== 1'b1 && n < STEP_LIM) begin #0.5; n++; end
    if (n >= STEP_LIM) return;
    t0 = $realtime;
    n = 0; while (probe(k) === 1'b1 && n < STEP_LIM) begin #0.5; n++; end
    t1 = $realtime;
    n = 0; while (probe(k) !== 1'b1 && n < STEP_LIM) begin #0.5; n++; end
    t2 = $realtime;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  task automatic apply_and_check(logic [1:0] s, logic oe);
    int per, hi, e;
    sel = s; out_en = oe;
    #1500;
    for (int k = 0; k < N_OUT; k++) begin
      e = exp_period(k, s, oe);
      measure(k, per, hi);
      if (e == 0) begin
        check((per == 0) && (oe ? (probe(k) === 1'b0) : (probe(k) !== 1'b1)),
              req_of(k, s, oe), $sformatf("out%0d idle sel=%b oe=%b", k, s, oe), per, 0);
      end else begin
        check(per == e, req_of(k, s, oe), $sformatf("out%0d period sel=%b", k, s), per, e);
        // R8: high time is half the period
        check(hi == e / 2, "R8", $sformatf("out%0d high time sel=%b", k, s), hi, e / 2);
      end
    end
  endtask

  initial begin
    int per, hi;
    logic [1:0] rs;
    logic roe;
    #0.25;
    void'($urandom(32'd5150));
    // R10: reset keeps divided outputs low; reference copies still pass through (R7)
    sel = 2'b11; out_en = 1'b1; rst = 1'b1;
    #300;
    for (int k = 0; k < 5; k++) begin
      check(probe(k) === 1'b0, "R10", $sformatf("out%0d in reset", k), int'(probe(k)), 0);
    end
    measure(1, per, hi);
    check(per == 0, "R10", "usb edges in reset", per, 0);
    measure(5, per, hi);
    check(per == 70, "R7", "ref copy in reset", per, 70);
    #100;
    rst = 1'b0;

    // Directed modes
    apply_and_check(2'b11, 1'b1);
    apply_and_check(2'b00, 1'b1);
    apply_and_check(2'b01, 1'b1);
    apply_and_check(2'b10, 1'b1);
    apply_and_check(2'b01, 1'b0);
    apply_and_check(2'b00, 1'b0);
    apply_and_check(2'b11, 1'b1);

    // R9: handoffs across every source pair while pulse widths are tracked
    mon_on = 1'b1;
    sel = 2'b00; #1000; sel = 2'b01; #1000; sel = 2'b10; #1000; sel = 2'b00; #1000;
    sel = 2'b10; #1000; sel = 2'b01; #1000; sel = 2'b11; #1000; sel = 2'b01; #1000;
    sel = 2'b00; #1000;
    mon_on = 1'b0;
    check(int'(min_a) >= 14, "R9", "shortest aud2x high pulse", int'(min_a), 14);
    check(int'(min_u) >= 10, "R9", "shortest usb high pulse", int'(min_u), 10);

    // Constrained random modes
    for (int it = 0; it < 14; it++) begin
      rs  = 2'($urandom_range(3));
      roe = ($urandom_range(3) != 0);
      apply_and_check(rs, roe);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule